// File: doc/BRIEF.md
# Stretchable External Bus Cycle Sequencer

This block runs one external data-memory transfer at a time over a multiplexed bus. The low address byte and the data byte share one bus. A latch-enable pulse marks when the low address is valid. Separate active-low read and write strobes move the data, and an active-low chip enable frames the whole transfer. The high address byte has a bus of its own and stays driven. A core raises a request with address, direction, write data and a 3-bit stretch code. While the cycle runs, the sequencer reports busy. At the end it gives a one-tick done pulse, and after a read it presents the captured byte.

The block clock runs at twice the rate of the core clock, so one tick is one half-clock phase. This lets the half-clock offsets be produced exactly. The stretch code selects one of three timing regimes: code 0, codes 1 to 3, and codes 4 to 7. In the slowest regime both the address setup and the trailing hold grow to several clocks, not only the strobe. The strobe width also grows in steps of four clocks for each code.

Top module: `xbus_seq`

## Requirements
- R1: After reset, ale_o is 0, rd_n_o, wr_n_o and ce_n_o are 1, ad_oe_o is 0, busy_o and done_o are 0, and rdata_o is 0.
- R2: A request taken in idle starts the latch-enable phase on the next tick. ale_o stays high for L ticks, with L=1 for code 0, L=2 for codes 1-3 and L=10 for codes 4-7. During this phase ad_oe_o is 1, ad_out_o carries address bits [7:0], and ahi_o carries address bits [15:8] for the whole cycle.
- R3: After ale_o falls, the strobe falls L ticks later. On a write the low address stays driven in that gap. On a read ad_oe_o drops when ale_o falls and stays 0 until the cycle ends.
- R4: The strobe stays low for 4 ticks at code 0 and for 8×code ticks otherwise. Only rd_n_o falls on a read (req_we_i=0), and only wr_n_o falls on a write (req_we_i=1).
- R5: On a write, ad_out_o carries the write data with ad_oe_o high from the strobe's falling tick until the cycle ends. That covers T ticks after the strobe rises, with T=2 for code 0, T=4 for codes 1-3 and T=12 for codes 4-7.
- R6: ce_n_o is low from the first latch-enable tick until T-1 ticks after the strobe rises. It is high on the last tick of the cycle.
- R7: A read captures ad_in_i at the clock edge that ends the last strobe-low tick. rdata_o shows that byte from done onward and keeps it through later write cycles.
- R8: done_o is high for exactly one tick, on the tick after the last cycle tick. busy_o is high on every cycle tick and low on the done tick. A request raised while busy_o is high is ignored.
- R9: Code, direction, address and write data are sampled when the request is taken. Changes to these inputs during the cycle have no effect on its timing or its bus values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock (two ticks per core clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request, taken when idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Transfer address |
| req_wdata_i | input | DATA_W | Write data |
| cst_i | input | 3 | Stretch code |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-tick end-of-cycle pulse |
| rdata_o | output | DATA_W | Last captured read byte |
| ale_o | output | 1 | Low-address latch enable |
| ad_out_o | output | DATA_W | Multiplexed bus output value |
| ad_oe_o | output | 1 | Multiplexed bus output enable |
| ad_in_i | input | DATA_W | Multiplexed bus input value |
| ahi_o | output | ADDR_W-DATA_W | High address byte |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| ce_n_o | output | 1 | Active-low chip enable |

## Verification
The bench builds the block with its default widths: an 8-bit shared bus and a 16-bit address. With a 3-bit code, all eight stretch codes can be reached, so each code is run in both directions by directed cycles. Random cycles then add more of them. In these random cycles the request stays raised and the operand inputs are scrambled during the cycle, and the bus input is driven with the right byte only on the one capture tick. This exposes any off-by-one in the phase lengths, any late sampling of operands, and any capture on the wrong edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int CST_W = 3;
  // longest phase is 8*7 = 56 ticks
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STROBE,
    PH_TRAIL
  } phase_e;

  // ticks of latch-enable high, and also of the gap from its fall to the strobe
  function automatic logic [CNT_W-1:0] lead_ticks(input logic [CST_W-1:0] c);
    if (c == '0)      return 6'd1;
    else if (c[2])    return 6'd10;
    else              return 6'd2;
  endfunction

  // ticks the strobe stays low
  function automatic logic [CNT_W-1:0] strobe_ticks(input logic [CST_W-1:0] c);
    if (c == '0) return 6'd4;
    else         return {c, 3'b000};
  endfunction

  // ticks after the strobe rises, up to the end of the cycle
  function automatic logic [CNT_W-1:0] trail_ticks(input logic [CST_W-1:0] c);
    if (c == '0)      return 6'd2;
    else if (c[2])    return 6'd12;
    else              return 6'd4;
  endfunction

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CST_W-1:0] cst_i,
  output phase_e           phase_o,
  output logic             last_o,
  output logic             accept_o,
  output logic             cap_o,
  output logic             busy_o,
  output logic             done_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CST_W-1:0] cst_q;
  logic             done_q;

  wire last_tick = (cnt_q == '0);
  wire accept    = (phase_q == PH_IDLE) && req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cst_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_ALE;
          cnt_q   <= lead_ticks(cst_i) - 6'd1;
          cst_q   <= cst_i;
        end
        PH_ALE: if (last_tick) begin
          phase_q <= PH_SETUP;
          cnt_q   <= lead_ticks(cst_q) - 6'd1;
        end else cnt_q <= cnt_q - 6'd1;
        PH_SETUP: if (last_tick) begin
          phase_q <= PH_STROBE;
          cnt_q   <= strobe_ticks(cst_q) - 6'd1;
        end else cnt_q <= cnt_q - 6'd1;
        PH_STROBE: if (last_tick) begin
          phase_q <= PH_TRAIL;
          cnt_q   <= trail_ticks(cst_q) - 6'd1;
        end else cnt_q <= cnt_q - 6'd1;
        PH_TRAIL: if (last_tick) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else cnt_q <= cnt_q - 6'd1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign last_o   = last_tick;
  assign accept_o = accept;
  assign cap_o    = (phase_q == PH_STROBE) && last_tick;
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;

  AST_DONE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE)); // R8
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(cst_q)); // R9
  AST_ALE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ALE) |-> (cnt_q < 6'd10)); // R2

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              cap_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_in_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  wire read_capture = cap_i && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (read_capture) rdata_q <= ad_in_i;
    end
  end

  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  AST_RDATA_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(read_capture)); // R7

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic              last_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ale_o,
  output logic [DATA_W-1:0] ad_out_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   ahi_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              ce_n_o
);

  wire in_cycle   = (phase_i != PH_IDLE);
  wire addr_phase = (phase_i == PH_ALE) || (phase_i == PH_SETUP);
  wire strobe_on  = (phase_i == PH_STROBE);

  always_comb begin
    ale_o    = (phase_i == PH_ALE);
    ad_out_o = addr_phase ? addr_i[DATA_W-1:0] : wdata_i;
    ad_oe_o  = (phase_i == PH_ALE) || (we_i && in_cycle);
    ahi_o    = addr_i[ADDR_W-1:DATA_W];
    rd_n_o   = !(strobe_on && !we_i);
    wr_n_o   = !(strobe_on && we_i);
    ce_n_o   = !in_cycle || ((phase_i == PH_TRAIL) && last_i);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n_o || wr_n_o); // R4
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n_o && wr_n_o)); // R3
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o); // R3
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> ad_oe_o); // R5
  AST_CE_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o || ale_o) |-> !ce_n_o); // R6

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [2:0]        cst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ale_o,
  output logic [DATA_W-1:0] ad_out_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_in_i,
  output logic [HI_W-1:0]   ahi_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              ce_n_o
);

  phase_e            phase;
  logic              last_tick;
  logic              accept;
  logic              capture;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  xbus_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .cst_i    (cst_i),
    .phase_o  (phase),
    .last_o   (last_tick),
    .accept_o (accept),
    .cap_o    (capture),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  xbus_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .cap_i    (capture),
    .we_i     (req_we_i),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .ad_in_i  (ad_in_i),
    .we_o     (we_q),
    .addr_o   (addr_q),
    .wdata_o  (wdata_q),
    .rdata_o  (rdata_o)
  );

  xbus_pins #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .last_i   (last_tick),
    .we_i     (we_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .ale_o    (ale_o),
    .ad_out_o (ad_out_o),
    .ad_oe_o  (ad_oe_o),
    .ahi_o    (ahi_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .ce_n_o   (ce_n_o)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o); // R8

endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [2:0]    cst = '0;
  logic [DW-1:0] ad_in = '0;
  logic          busy, done, ale, ad_oe, rd_n, wr_n, ce_n;
  logic [DW-1:0] rdata, ad_out;
  logic [AW-DW-1:0] ahi;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [DW-1:0] last_rv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_seq #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .cst_i(cst),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .ale_o(ale),
    .ad_out_o(ad_out), .ad_oe_o(ad_oe), .ad_in_i(ad_in), .ahi_o(ahi),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .ce_n_o(ce_n)
  );

  // phase lengths in half-clock ticks, restated from clock counts
  function automatic int exp_lead(input int c);
    if (c == 0) return 1;
    return (c <= 3) ? 2 * 1 : 2 * 5;
  endfunction
  function automatic int exp_strobe(input int c);
    return (c == 0) ? 2 * 2 : 2 * (4 * c);
  endfunction
  function automatic int exp_trail(input int c);
    if (c == 0) return 2 * 1;
    return (c <= 3) ? 2 * 2 : 2 * 6;
  endfunction

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input bit we, input int c, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                           input bit noise);
    int l, s, t, total, cap_i;
    logic [6:0] exp_ctl;
    bit exp_oe;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = wd; cst = c[2:0];
    ad_in = ~rv;
    l = exp_lead(c); s = exp_strobe(c); t = exp_trail(c);
    total = 2 * l + s + t;
    cap_i = 2 * l + s - 1;
    for (int i = 0; i <= total; i++) begin
      @(negedge clk);
      if (i < total) begin
        exp_oe = (i < l) || we;
        // {ale, rd_n, wr_n, ce_n, oe, busy, done}
        exp_ctl = {i < l,
                   !(!we && i >= 2*l && i < 2*l+s),
                   !(we && i >= 2*l && i < 2*l+s),
                   i == total - 1,
                   exp_oe, 1'b1, 1'b0};
        if (i < l)
          check("R2", "ctl ale phase", {25'd0, ale, rd_n, wr_n, ce_n, ad_oe, busy, done}, {25'd0, exp_ctl});
        else if (i < 2*l)
          check("R3", "ctl setup phase", {25'd0, ale, rd_n, wr_n, ce_n, ad_oe, busy, done}, {25'd0, exp_ctl});
        else if (i < 2*l+s)
          check("R4", "ctl strobe phase", {25'd0, ale, rd_n, wr_n, ce_n, ad_oe, busy, done}, {25'd0, exp_ctl});
        else
          check("R6", "ctl trail phase", {25'd0, ale, rd_n, wr_n, ce_n, ad_oe, busy, done}, {25'd0, exp_ctl});
        check("R2", "ahi", {24'd0, ahi}, {24'd0, a[AW-1:DW]});
        if (i < 2*l && exp_oe)
          check("R2", "bus low address", {24'd0, ad_out}, {24'd0, a[DW-1:0]});
        else if (i >= 2*l && we)
          check("R5", "bus write data", {24'd0, ad_out}, {24'd0, wd});
      end else begin
        if (!we) last_rv = rv;
        check("R8", "done/busy at end", {30'd0, done, busy}, {30'd0, 2'b10});
        check("R6", "ce/strobes/oe at end", {28'd0, ale, ce_n, rd_n && wr_n, ad_oe}, {28'd0, 4'b0110});
        check("R7", "read data", {24'd0, rdata}, {24'd0, last_rv});
      end
      // drive for the edge that ends tick i
      if (i >= total - 2) req = 1'b0;
      else if (noise) begin
        req = 1'b1;                   // R8: ignored while busy
        req_we = $urandom_range(0, 1);
        req_addr = AW'($urandom);     // R9: operands changing mid-cycle
        req_wdata = DW'($urandom);
        cst = 3'($urandom);
      end else req = 1'b0;
      ad_in = (i == cap_i) ? rv : DW'($urandom) ^ rv ^ 8'h5A;
      if (i != cap_i && ad_in == rv) ad_in = ~rv;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset ctl", {25'd0, ale, rd_n, wr_n, ce_n, ad_oe, busy, done}, {25'd0, 7'b0111000});
    check("R1", "reset rdata", {24'd0, rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {25'd0, ale, rd_n, wr_n, ce_n, ad_oe, busy, done}, {25'd0, 7'b0111000});
    // directed: every code in both directions, both regime edges included
    for (int c = 0; c < 8; c++) begin
      run_cycle(1'b0, c, 16'hA500 + 16'(c), 8'h00, 8'hC0 + 8'(c), 1'b0);
      run_cycle(1'b1, c, 16'h3C80 + 16'(c), 8'h90 + 8'(c), 8'h00, 1'b0);
    end
    // R7: rdata kept across a write
    run_cycle(1'b1, 7, 16'hFFFF, 8'hFF, 8'h00, 1'b1);
    // constrained random, with mid-cycle request noise
    for (int k = 0; k < 40; k++) begin
      run_cycle(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                AW'($urandom), DW'($urandom), DW'($urandom), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule